// File: doc/BRIEF.md
# Lazy Floating-Point Context State Updater

When an exception is taken with deferred floating-point register saving turned on, the core does not spill the floating-point registers straight away. Instead it records where they would go and under what conditions the deferred save may later run. This block does that recording. On a single-cycle update strobe, it captures an 8-byte aligned frame address and a set of control and status bits. These go into a pair of banked registers. Each register has one copy for the secure state and one copy for the non-secure state.

Each captured bit has a fixed destination copy:
- Some bits always go to the secure copy, whatever the current state.
- Some bits go to the copy of the security state the core is in.
- The non-secure usage-fault ready flag always goes to the non-secure copy, even when the core is secure.

A stack-limit check can also be applied. Its violation flag is suppressed when a negative-priority request is pending and the overflow-ignore control is set. The ready flags are computed elsewhere and arrive here as plain inputs. The later register save is done by another block.

The strobe is a plain control pulse with no handshake. The block accepts it in every cycle and never applies back-pressure, so a caller may pulse it on back-to-back cycles. Parameters select the address width (`ADDR_W`), whether the security extension is present (`HAS_SEC`), and whether stack-limit checking exists (`HAS_SPLIM`).

Top module: `lfp_ctx_update`

## Requirements

The control word is 11 bits wide, with these bit positions:

| Bit | Field |
|---|---|
| 0 | lazy-active |
| 1 | user |
| 2 | thread |
| 3 | hard-fault ready |
| 4 | memory-management ready |
| 5 | bus-fault ready |
| 6 | monitor ready |
| 7 | usage-fault ready |
| 8 | secure-fault ready |
| 9 | limit-violation |
| 10 | security-state |

The "current bank" is the secure copy when `sec_state_i` is 1, and the non-secure copy when it is 0.

- R1: While `rst_n` is low, and in the first cycle after it rises, both address outputs and both control outputs are zero.
- R2: Each strobe writes the frame pointer into the current bank's address register, with bits [2:0] forced to 0. The next cycle shows this value. The other bank's address register is unchanged.
- R3: Each strobe sets bit 0 (lazy-active) of the current bank's control word.
- R4: Each strobe writes bit 1 (user) of the current bank as `priv0_i`. It writes bit 2 (thread) of the current bank as the inverse of `handler_i`.
- R5: Each strobe writes `sec_state_i` into bit 10 of the secure control copy. Bit 10 of the non-secure copy is never written and stays 0.
- R6: Each strobe writes the hard-fault, bus-fault and monitor ready inputs into bits 3, 5 and 6 of the secure copy, in either security state. These bits of the non-secure copy stay 0.
- R7: Each strobe writes `mm_rdy_i` into bit 4 of the current bank only. Bit 4 of the other bank is unchanged.
- R8: Each strobe writes `uf_ns_rdy_i` into bit 7 of the non-secure copy, including when `sec_state_i` is 1.
- R9: With `HAS_SEC`=1, each strobe writes `uf_s_rdy_i` into bit 7 and `sf_rdy_i` into bit 8 of the secure copy. With `HAS_SEC`=0, these two bits are never written.
- R10: With `HAS_SPLIM`=1 and `apply_lim_i`=1, a strobe writes bit 9 of the current bank. The value written is (`frame_ptr_i` < `sp_limit_i`, unsigned) AND NOT (`negpri_pend_i` AND `ovf_ign_ctl_i`). With `apply_lim_i`=0, bit 9 is unchanged.
- R11: In any cycle without the strobe, all four registers hold their values, whatever the other inputs do.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_i | input | 1 | Update strobe, one cycle per capture |
| frame_ptr_i | input | ADDR_W | Frame pointer of the floating-point save area |
| sec_state_i | input | 1 | 1 = core is in the secure state |
| priv0_i | input | 1 | 1 = running at privilege level 0 |
| handler_i | input | 1 | 1 = handler mode, 0 = thread mode |
| apply_lim_i | input | 1 | Apply the stack-limit check on this update |
| sp_limit_i | input | ADDR_W | Active stack limit |
| ovf_ign_ctl_i | input | 1 | Overflow-ignore control for negative-priority handlers |
| negpri_pend_i | input | 1 | A negative-priority request is pending |
| hf_rdy_i | input | 1 | Hard-fault ready |
| bf_rdy_i | input | 1 | Bus-fault ready |
| mm_rdy_i | input | 1 | Memory-management ready, for the current state |
| mon_rdy_i | input | 1 | Debug-monitor ready |
| uf_ns_rdy_i | input | 1 | Non-secure usage-fault ready |
| uf_s_rdy_i | input | 1 | Secure usage-fault ready |
| sf_rdy_i | input | 1 | Secure-fault ready |
| addr_s_o | output | ADDR_W | Secure context-address register |
| addr_ns_o | output | ADDR_W | Non-secure context-address register |
| ctl_s_o | output | 11 | Secure context-control register |
| ctl_ns_o | output | 11 | Non-secure context-control register |

## Verification

The bench targets the bank-routing corners, because each one maps to a plausible wiring mistake:
- A secure-state update must still land the non-secure usage-fault flag in the non-secure copy. A design that routed it to the current bank would leave that bit stale.
- A non-secure update must change no current-bank field of the secure copy. A design that wrote both banks would overwrite the secure user, thread and memory-management bits.

The limit check is driven in three ways:
- Just below the limit: the flag is set.
- Equal to the limit: the flag is clear. An inclusive comparator would set it here.
- Below the limit with the ignore condition true: the flag is clear. A design missing either term of the ignore AND would set it here.

An update with the check not applied must leave an earlier violation in place. Address inputs with non-zero low bits show any failure to align the frame address.

// File: rtl/lfp_pkg.sv
package lfp_pkg;
  localparam int CTL_W = 11;

  localparam int B_LAZY   = 0;
  localparam int B_USER   = 1;
  localparam int B_THREAD = 2;
  localparam int B_HF     = 3;
  localparam int B_MM     = 4;
  localparam int B_BF     = 5;
  localparam int B_MON    = 6;
  localparam int B_UF     = 7;
  localparam int B_SF     = 8;
  localparam int B_LIM    = 9;
  localparam int B_SEC    = 10;

  typedef struct packed {
    logic sec_state;
    logic lim_viol;
    logic sf_rdy;
    logic uf_rdy;
    logic mon_rdy;
    logic bf_rdy;
    logic mm_rdy;
    logic hf_rdy;
    logic thread;
    logic user;
    logic lazy_act;
  } ctl_t;

  typedef struct packed {
    logic sec_state;
    logic priv0;
    logic handler;
    logic hf;
    logic bf;
    logic mm;
    logic mon;
    logic uf_ns;
    logic uf_s;
    logic sf;
  } ctx_in_t;
endpackage

// File: rtl/lfp_limit_chk.sv
module lfp_limit_chk #(
  parameter int ADDR_W    = 32,
  parameter bit HAS_SPLIM = 1'b1
) (
  input  logic              apply_i,
  input  logic [ADDR_W-1:0] frame_i,
  input  logic [ADDR_W-1:0] limit_i,
  input  logic              ign_ctl_i,
  input  logic              negpri_i,
  output logic              we_o,
  output logic              viol_o
);
  logic below;
  logic ign;

  generate
    if (HAS_SPLIM) begin : g_lim
      always_comb begin
        below  = (frame_i < limit_i);
        ign    = negpri_i & ign_ctl_i;
        we_o   = apply_i;
        viol_o = below & ~ign;
      end
    end else begin : g_nolim
      always_comb begin
        below  = 1'b0;
        ign    = 1'b0;
        we_o   = 1'b0;
        viol_o = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/lfp_bank_next.sv
module lfp_bank_next
  import lfp_pkg::*;
#(
  parameter bit BANK_IS_SEC = 1'b0,
  parameter bit HAS_SEC     = 1'b1
) (
  input  ctl_t    cur_i,
  input  ctx_in_t in_i,
  input  logic    lim_we_i,
  input  logic    lim_viol_i,
  output ctl_t    nxt_o
);
  logic own;

  always_comb begin
    own   = (in_i.sec_state == BANK_IS_SEC);
    nxt_o = cur_i;
    if (own) begin
      nxt_o.lazy_act = 1'b1;
      nxt_o.user     = in_i.priv0;
      nxt_o.thread   = ~in_i.handler;
      nxt_o.mm_rdy   = in_i.mm;
      if (lim_we_i) nxt_o.lim_viol = lim_viol_i;
    end
    if (BANK_IS_SEC) begin
      nxt_o.sec_state = in_i.sec_state;
      nxt_o.hf_rdy    = in_i.hf;
      nxt_o.bf_rdy    = in_i.bf;
      nxt_o.mon_rdy   = in_i.mon;
      if (HAS_SEC) begin
        nxt_o.uf_rdy = in_i.uf_s;
        nxt_o.sf_rdy = in_i.sf;
      end
    end else begin
      nxt_o.uf_rdy = in_i.uf_ns;
    end
  end
endmodule

// File: rtl/lfp_ctx_update.sv
module lfp_ctx_update
  import lfp_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter bit HAS_SEC   = 1'b1,
  parameter bit HAS_SPLIM = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_i,
  input  logic [ADDR_W-1:0] frame_ptr_i,
  input  logic              sec_state_i,
  input  logic              priv0_i,
  input  logic              handler_i,
  input  logic              apply_lim_i,
  input  logic [ADDR_W-1:0] sp_limit_i,
  input  logic              ovf_ign_ctl_i,
  input  logic              negpri_pend_i,
  input  logic              hf_rdy_i,
  input  logic              bf_rdy_i,
  input  logic              mm_rdy_i,
  input  logic              mon_rdy_i,
  input  logic              uf_ns_rdy_i,
  input  logic              uf_s_rdy_i,
  input  logic              sf_rdy_i,
  output logic [ADDR_W-1:0] addr_s_o,
  output logic [ADDR_W-1:0] addr_ns_o,
  output logic [CTL_W-1:0]  ctl_s_o,
  output logic [CTL_W-1:0]  ctl_ns_o
);
  localparam int NBANK = 2;
  localparam int ALIGN = 3;

  ctx_in_t           ctx_in;
  logic              lim_we;
  logic              lim_viol;
  logic [ADDR_W-1:0] frame_al;
  ctl_t              ctl_q   [NBANK];
  ctl_t              ctl_nxt [NBANK];
  logic [ADDR_W-1:0] addr_q  [NBANK];

  always_comb begin
    ctx_in.sec_state = sec_state_i;
    ctx_in.priv0     = priv0_i;
    ctx_in.handler   = handler_i;
    ctx_in.hf        = hf_rdy_i;
    ctx_in.bf        = bf_rdy_i;
    ctx_in.mm        = mm_rdy_i;
    ctx_in.mon       = mon_rdy_i;
    ctx_in.uf_ns     = uf_ns_rdy_i;
    ctx_in.uf_s      = uf_s_rdy_i;
    ctx_in.sf        = sf_rdy_i;
    frame_al         = {frame_ptr_i[ADDR_W-1:ALIGN], {ALIGN{1'b0}}};
  end

  lfp_limit_chk #(
    .ADDR_W   (ADDR_W),
    .HAS_SPLIM(HAS_SPLIM)
  ) u_lim (
    .apply_i  (apply_lim_i),
    .frame_i  (frame_ptr_i),
    .limit_i  (sp_limit_i),
    .ign_ctl_i(ovf_ign_ctl_i),
    .negpri_i (negpri_pend_i),
    .we_o     (lim_we),
    .viol_o   (lim_viol)
  );

  // bank index 0 = non-secure copy, 1 = secure copy
  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      lfp_bank_next #(
        .BANK_IS_SEC(b == 1),
        .HAS_SEC    (HAS_SEC)
      ) u_next (
        .cur_i     (ctl_q[b]),
        .in_i      (ctx_in),
        .lim_we_i  (lim_we),
        .lim_viol_i(lim_viol),
        .nxt_o     (ctl_nxt[b])
      );

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ctl_q[b]  <= '0;
          addr_q[b] <= '0;
        end else if (upd_i) begin
          ctl_q[b] <= ctl_nxt[b];
          if (sec_state_i == (b == 1)) addr_q[b] <= frame_al;
        end
      end
    end
  endgenerate

  assign addr_s_o  = addr_q[1];
  assign addr_ns_o = addr_q[0];
  assign ctl_s_o   = ctl_q[1];
  assign ctl_ns_o  = ctl_q[0];

  // R2: address lands aligned in the current bank
  a_r2_addr_sec: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && sec_state_i) |=>
      (addr_s_o[ALIGN-1:0] == '0) &&
      (addr_s_o[ADDR_W-1:ALIGN] == $past(frame_ptr_i[ADDR_W-1:ALIGN])) &&
      $stable(addr_ns_o));
  a_r2_addr_nsec: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && !sec_state_i) |=>
      (addr_ns_o[ALIGN-1:0] == '0) &&
      (addr_ns_o[ADDR_W-1:ALIGN] == $past(frame_ptr_i[ADDR_W-1:ALIGN])) &&
      $stable(addr_s_o));

  // R3: lazy-active set in the current bank
  a_r3_lazy_set: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |=> ($past(sec_state_i) ? ctl_s_o[B_LAZY] : ctl_ns_o[B_LAZY]));

  // R8: non-secure usage-fault flag always reaches the non-secure copy
  a_r8_ns_uf: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |=> ctl_ns_o[B_UF] == $past(uf_ns_rdy_i));

  // R10: ignore condition forces the violation flag clear
  a_r10_ign_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && apply_lim_i && negpri_pend_i && ovf_ign_ctl_i && HAS_SPLIM) |=>
      !($past(sec_state_i) ? ctl_s_o[B_LIM] : ctl_ns_o[B_LIM]));

  // R11: nothing moves without the strobe
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(ctl_s_o) && $stable(ctl_ns_o) &&
               $stable(addr_s_o) && $stable(addr_ns_o));
endmodule

// File: tb/lfp_ctx_update_tb_top.sv
module lfp_ctx_update_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          upd = 1'b0;
  logic [AW-1:0] frame = '0;
  logic          sec = 1'b0, priv0 = 1'b0, handler = 1'b0, apply_lim = 1'b0;
  logic [AW-1:0] limit = '0;
  logic          ign_ctl = 1'b0, negpri = 1'b0;
  logic          hf = 1'b0, bf = 1'b0, mm = 1'b0, mon = 1'b0;
  logic          uf_ns = 1'b0, uf_s = 1'b0, sf = 1'b0;
  logic [AW-1:0] addr_s, addr_ns;
  logic [10:0]   ctl_s, ctl_ns;

  logic [AW-1:0] ea_s = '0, ea_ns = '0;
  logic [10:0]   ec_s = '0, ec_ns = '0;
  int            n_run = 0;
  int            n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lfp_ctx_update dut_i (
    .clk(clk), .rst_n(rst_n), .upd_i(upd), .frame_ptr_i(frame),
    .sec_state_i(sec), .priv0_i(priv0), .handler_i(handler),
    .apply_lim_i(apply_lim), .sp_limit_i(limit), .ovf_ign_ctl_i(ign_ctl),
    .negpri_pend_i(negpri), .hf_rdy_i(hf), .bf_rdy_i(bf), .mm_rdy_i(mm),
    .mon_rdy_i(mon), .uf_ns_rdy_i(uf_ns), .uf_s_rdy_i(uf_s), .sf_rdy_i(sf),
    .addr_s_o(addr_s), .addr_ns_o(addr_ns), .ctl_s_o(ctl_s), .ctl_ns_o(ctl_ns)
  );

  task automatic chk(string req, string what, logic [AW-1:0] got, logic [AW-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // reference model of one update, written from the requirements
  task automatic model_update();
    logic [10:0] cur;
    cur = sec ? ec_s : ec_ns;
    cur[0] = 1'b1;
    cur[1] = priv0;
    cur[2] = ~handler;
    cur[4] = mm;
    if (apply_lim) cur[9] = (frame < limit) && !(negpri && ign_ctl);
    if (sec) begin ec_s = cur; ea_s = {frame[AW-1:3], 3'b000}; end
    else     begin ec_ns = cur; ea_ns = {frame[AW-1:3], 3'b000}; end
    ec_s[10] = sec; ec_s[3] = hf; ec_s[5] = bf; ec_s[6] = mon;
    ec_s[7] = uf_s; ec_s[8] = sf;
    ec_ns[7] = uf_ns;
  endtask

  task automatic pulse();
    @(negedge clk);
    upd = 1'b1;
    model_update();
    @(negedge clk);
    upd = 1'b0;
  endtask

  task automatic chk_all(string req);
    chk(req, "addr_s", addr_s, ea_s);
    chk(req, "addr_ns", addr_ns, ea_ns);
    chk(req, "ctl_s", {21'd0, ctl_s}, {21'd0, ec_s});
    chk(req, "ctl_ns", {21'd0, ctl_ns}, {21'd0, ec_ns});
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "addr_s", addr_s, '0);
    chk("R1", "addr_ns", addr_ns, '0);
    chk("R1", "ctl_s", {21'd0, ctl_s}, '0);
    chk("R1", "ctl_ns", {21'd0, ctl_ns}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ctl after release", {21'd0, ctl_s | ctl_ns}, '0);
  endtask

  task automatic t_nonsec_entry();
    sec = 0; priv0 = 1; handler = 0; frame = 32'h2000_0F27;
    hf = 1; bf = 0; mon = 1; mm = 1; uf_ns = 1; uf_s = 0; sf = 1; apply_lim = 0;
    pulse();
    chk("R2", "ns addr aligned", addr_ns, 32'h2000_0F20);
    chk("R2", "s addr untouched", addr_s, '0);
    chk("R3", "ns lazy", {31'd0, ctl_ns[0]}, 1);
    chk("R4", "ns user", {31'd0, ctl_ns[1]}, 1);
    chk("R4", "ns thread", {31'd0, ctl_ns[2]}, 1);
    chk("R5", "s secbit", {31'd0, ctl_s[10]}, 0);
    chk("R6", "s hf/bf/mon", {29'd0, ctl_s[6], ctl_s[5], ctl_s[3]}, 3'b101);
    chk("R6", "ns hf/bf/mon", {29'd0, ctl_ns[6], ctl_ns[5], ctl_ns[3]}, 3'b000);
    chk("R7", "ns mm", {31'd0, ctl_ns[4]}, 1);
    chk("R7", "s mm untouched", {31'd0, ctl_s[4]}, 0);
    chk("R8", "ns uf", {31'd0, ctl_ns[7]}, 1);
    chk("R9", "s sf", {31'd0, ctl_s[8]}, 1);
    chk_all("R2");
  endtask

  task automatic t_sec_entry();
    sec = 1; priv0 = 0; handler = 1; frame = 32'h3000_1045;
    hf = 0; bf = 1; mon = 0; mm = 0; uf_ns = 0; uf_s = 1; sf = 0;
    pulse();
    chk("R2", "s addr aligned", addr_s, 32'h3000_1040);
    chk("R2", "ns addr kept", addr_ns, 32'h2000_0F20);
    chk("R3", "s lazy", {31'd0, ctl_s[0]}, 1);
    chk("R4", "s user/thread", {30'd0, ctl_s[2], ctl_s[1]}, 2'b00);
    chk("R5", "s secbit", {31'd0, ctl_s[10]}, 1);
    chk("R5", "ns secbit", {31'd0, ctl_ns[10]}, 0);
    chk("R7", "ns mm kept", {31'd0, ctl_ns[4]}, 1);
    chk("R8", "ns uf while secure", {31'd0, ctl_ns[7]}, 0);
    chk("R9", "s uf", {31'd0, ctl_s[7]}, 1);
    chk("R4", "ns user kept", {31'd0, ctl_ns[1]}, 1);
    chk_all("R8");
  endtask

  task automatic t_limit();
    sec = 0; apply_lim = 1; limit = 32'h0000_8000;
    frame = 32'h0000_7FFF; negpri = 0; ign_ctl = 0;
    pulse();
    chk("R10", "below limit", {31'd0, ctl_ns[9]}, 1);
    apply_lim = 0; frame = 32'h0000_9000;
    pulse();
    chk("R10", "not applied keeps", {31'd0, ctl_ns[9]}, 1);
    apply_lim = 1; frame = 32'h0000_8000;
    pulse();
    chk("R10", "equal limit", {31'd0, ctl_ns[9]}, 0);
    frame = 32'h0000_1000; negpri = 1; ign_ctl = 1;
    pulse();
    chk("R10", "ignored", {31'd0, ctl_ns[9]}, 0);
    negpri = 1; ign_ctl = 0;
    pulse();
    chk("R10", "ctl off no ignore", {31'd0, ctl_ns[9]}, 1);
    sec = 1; negpri = 0; frame = 32'h0000_0100;
    pulse();
    chk("R10", "secure bank", {31'd0, ctl_s[9]}, 1);
    chk_all("R10");
  endtask

  task automatic t_hold();
    @(negedge clk);
    sec = ~sec; frame = 32'hDEAD_BEEF; priv0 = ~priv0; handler = ~handler;
    hf = ~hf; bf = ~bf; mm = ~mm; mon = ~mon; uf_ns = ~uf_ns; uf_s = ~uf_s; sf = ~sf;
    apply_lim = 1; limit = '1;
    repeat (3) @(negedge clk);
    chk_all("R11");
  endtask

  initial begin
    fork
      begin
        repeat (2) @(negedge clk);
        t_reset();
        t_nonsec_entry();
        t_sec_entry();
        t_limit();
        t_hold();
      end
      begin
        repeat (5000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule